// File: doc/BRIEF.md
# Node Memory Row Protection Guard

This block sits between a node's incoming host requests and its local 128-row, 32-bit data memory. Every host request names one row and is either a read or a write. The block looks up a two-bit protection code for that row. It then performs the access or refuses it. When it refuses, it reports why through one of two error flags, and the reply-building logic downstream copies those flags into the write-reply frame.

Local firmware sets the protection code of each row through a separate configuration port. A row can be left open, made read-only, or closed entirely. Writes that pass the check reach the memory in the same cycle as the request. Read data and the error flags appear together one cycle later, along with a response strobe.

The memory is split into a low part and a high part, one for each receiving interface. The response therefore also says which part the accessed row belongs to.

Top module: `node_row_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, rspValid, rspAddrErr, rspAccErr, rspHigh and memWe are 0, rspData is zero, and every row's protection code is 00 (open).
- R2: For a write to an open row, memWe is 1 in the request cycle and the row takes the write data at that clock edge. A read of the row in any later cycle returns that data one cycle after the read request, with both error flags 0.
- R3: Protection code 01 (read-only) allows reads: a read returns the stored word with no error flag set.
- R4: A write to a row with code 01 keeps memWe at 0 and leaves the row unchanged. One cycle later it sets rspAccErr=1 and rspAddrErr=0.
- R5: A write to a row with code 10 (closed) keeps memWe at 0 and leaves the row unchanged. One cycle later it sets rspAddrErr=1 and rspAccErr=0.
- R6: A read of a row with code 10 returns rspData all zeros, with rspAddrErr=1 and rspAccErr=0.
- R7: Code 11 behaves exactly like code 10 for both reads and writes.
- R8: A request address of 128 or more is treated as a closed row. It causes no write to any row, its read returns zeros, and it sets rspAddrErr=1. This holds even for addresses whose low 7 bits match a stored row.
- R9: rspValid is 1 exactly in the cycle after a cycle with reqValid=1, and 0 otherwise. rspData is zero in the response to a write.
- R10: A protection-code update written through the configuration port takes effect from the next cycle. A request in the same cycle as the update is checked against the old code. An update addressed to 128 or more changes no row.
- R11: rspHigh is 1 in a response exactly when the request addressed an in-range row at or above LOW_ROWS (default 64).
- R12: Setting a protected row back to code 00 restores normal access, and the row still holds the data it had before it was protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Requested row address |
| reqWdata | input | 32 | Write data |
| cfgValid | input | 1 | Protection-code update strobe |
| cfgAddr | input | 8 | Row whose code is updated |
| cfgAttr | input | 2 | New code: 00 open, 01 read-only, 10/11 closed |
| memWe | output | 1 | Memory write enable in the request cycle |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspData | output | 32 | Read data, zero when refused or for writes |
| rspAddrErr | output | 1 | Closed or out-of-range row |
| rspAccErr | output | 1 | Write refused by a read-only row |
| rspHigh | output | 1 | Accessed row lies in the high part |

## Verification
The hardest case to reach from the ports is a protection update and a host request that hit the same row in the same cycle. In that case the old code must decide the outcome. The bench drives both strobes in one cycle and writes an open row while making it read-only. It then checks that this write lands and that the following write is refused. A second difficult case is an out-of-range address whose low bits alias a live row. The bench writes a marker into the aliased row, sends a write to the aliasing address, and reads the marker back to confirm it survived.

// File: rtl/node_guard_pkg.sv
package node_guard_pkg;

  typedef enum logic [1:0] {
    ATTR_OPEN    = 2'b00,
    ATTR_RDONLY  = 2'b01,
    ATTR_CLOSED  = 2'b10,
    ATTR_CLOSED2 = 2'b11
  } rowAttr_e;

  typedef struct packed {
    logic rspEn;
    logic memWe;
    logic rdEn;
    logic addrErr;
    logic accErr;
  } guardCtl_t;

endpackage

// File: rtl/node_guard_ctrl.sv
module node_guard_ctrl
  import node_guard_pkg::*;
(
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      inRange,
  input  rowAttr_e  rowAttr,
  output guardCtl_t ctl
);

  logic closed;
  logic rdOnly;

  always_comb begin
    closed = !inRange || (rowAttr == ATTR_CLOSED) || (rowAttr == ATTR_CLOSED2);
    rdOnly = (rowAttr == ATTR_RDONLY);
    ctl.rspEn   = reqValid;
    ctl.addrErr = reqValid && closed;
    ctl.accErr  = reqValid && reqWrite && !closed && rdOnly;
    ctl.memWe   = reqValid && reqWrite && !closed && !rdOnly;
    ctl.rdEn    = reqValid && !reqWrite && !closed;
  end

endmodule

// File: rtl/node_guard_dp.sv
module node_guard_dp
  import node_guard_pkg::*;
#(
  parameter int ROWS     = 128,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int LOW_ROWS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgValid,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  rowAttr_e          cfgAttr,
  input  guardCtl_t         ctl,
  output rowAttr_e          rowAttr,
  output logic              inRange,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspAddrErr,
  output logic              rspAccErr,
  output logic              rspHigh
);

  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ADDR_W:0] ROWS_L = (ADDR_W+1)'(ROWS);
  localparam logic [ROW_W-1:0] SPLIT_L = ROW_W'(LOW_ROWS);

  logic [DATA_W-1:0] mem [ROWS];
  rowAttr_e attrTab [ROWS];

  logic [ROW_W-1:0] reqRow;
  logic [ROW_W-1:0] cfgRow;
  logic             cfgInRange;

  always_comb begin
    reqRow     = reqAddr[ROW_W-1:0];
    cfgRow     = cfgAddr[ROW_W-1:0];
    inRange    = {1'b0, reqAddr} < ROWS_L;
    cfgInRange = {1'b0, cfgAddr} < ROWS_L;
    rowAttr    = attrTab[reqRow];
  end

  always_ff @(posedge clk) begin
    if (ctl.memWe) mem[reqRow] <= reqWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) attrTab[i] <= ATTR_OPEN;
    end else if (cfgValid && cfgInRange) begin
      attrTab[cfgRow] <= cfgAttr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspData    <= '0;
      rspAddrErr <= 1'b0;
      rspAccErr  <= 1'b0;
      rspHigh    <= 1'b0;
    end else begin
      rspValid   <= ctl.rspEn;
      rspData    <= ctl.rdEn ? mem[reqRow] : '0;
      rspAddrErr <= ctl.addrErr;
      rspAccErr  <= ctl.accErr;
      rspHigh    <= reqValid && inRange && (reqRow >= SPLIT_L);
    end
  end

endmodule

// File: rtl/node_row_guard.sv
module node_row_guard
  import node_guard_pkg::*;
#(
  parameter int ROWS     = 128,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int LOW_ROWS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgValid,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgAttr,
  output logic              memWe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspAddrErr,
  output logic              rspAccErr,
  output logic              rspHigh
);

  guardCtl_t ctl;
  rowAttr_e  rowAttr;
  logic      inRange;

  node_guard_ctrl uCtrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .inRange  (inRange),
    .rowAttr  (rowAttr),
    .ctl      (ctl)
  );

  node_guard_dp #(
    .ROWS     (ROWS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LOW_ROWS (LOW_ROWS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .cfgValid   (cfgValid),
    .cfgAddr    (cfgAddr),
    .cfgAttr    (rowAttr_e'(cfgAttr)),
    .ctl        (ctl),
    .rowAttr    (rowAttr),
    .inRange    (inRange),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspAddrErr (rspAddrErr),
    .rspAccErr  (rspAccErr),
    .rspHigh    (rspHigh)
  );

  assign memWe = ctl.memWe;

endmodule

// File: rtl/node_guard_chk.sv
module node_guard_chk #(
  parameter int ROWS   = 128,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              memWe,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              rspAddrErr,
  input logic              rspAccErr,
  input logic              rspHigh
);

  localparam logic [ADDR_W:0] ROWS_L = (ADDR_W+1)'(ROWS);

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (reqValid && reqWrite)); // R2

  AST_OOR_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqAddr} >= ROWS_L)) |-> !memWe); // R8

  AST_OOR_ADDR_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqAddr} >= ROWS_L)) |=> (rspAddrErr && !rspHigh)); // R8

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R9

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R9

  AST_ERR_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspAddrErr, rspAccErr})); // R4

  AST_ACC_ERR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> !rspAccErr); // R3

  AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspAddrErr |-> (rspData == '0)); // R6

  AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspData == '0)); // R9

endmodule

bind node_row_guard node_guard_chk #(
  .ROWS   (ROWS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .memWe      (memWe),
  .rspValid   (rspValid),
  .rspData    (rspData),
  .rspAddrErr (rspAddrErr),
  .rspAccErr  (rspAccErr),
  .rspHigh    (rspHigh)
);

// File: tb/sim_node_row_guard.sv
`timescale 1ns/100ps
module sim_node_row_guard;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [7:0]  reqAddr;
  logic [31:0] reqWdata;
  logic        cfgValid;
  logic [7:0]  cfgAddr;
  logic [1:0]  cfgAttr;
  logic        memWe, rspValid, rspAddrErr, rspAccErr, rspHigh;
  logic [31:0] rspData;

  int checks = 0;
  int errors = 0;

  logic        oWe, oRv, oAe, oCe, oHi;
  logic [31:0] oData;

  always #2.5 clk = ~clk;

  node_row_guard u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .cfgValid(cfgValid),
    .cfgAddr(cfgAddr), .cfgAttr(cfgAttr), .memWe(memWe), .rspValid(rspValid),
    .rspData(rspData), .rspAddrErr(rspAddrErr), .rspAccErr(rspAccErr),
    .rspHigh(rspHigh)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; optional same-cycle config update
  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic cv, input logic [7:0] ca, input logic [1:0] cattr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    cfgValid = cv; cfgAddr = ca; cfgAttr = cattr;
    #1 oWe = memWe;
    @(posedge clk);
    #1;
    oRv = rspValid; oAe = rspAddrErr; oCe = rspAccErr; oHi = rspHigh; oData = rspData;
    reqValid = 1'b0; cfgValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    access(1'b1, a, d, 1'b0, 8'd0, 2'b00);
  endtask

  task automatic rd(input logic [7:0] a);
    access(1'b0, a, 32'd0, 1'b0, 8'd0, 2'b00);
  endtask

  task automatic setAttr(input logic [7:0] a, input logic [1:0] v);
    @(negedge clk);
    cfgValid = 1'b1; cfgAddr = a; cfgAttr = v;
    @(posedge clk);
    #1 cfgValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; reqValid = 0; reqWrite = 0; reqAddr = 0; reqWdata = 0;
    cfgValid = 0; cfgAddr = 0; cfgAttr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rspValid in reset", {31'd0, rspValid}, 32'd0);
    chk("R1 flags in reset", {29'd0, rspAddrErr, rspAccErr, rspHigh}, 32'd0);
    chk("R1 memWe in reset", {31'd0, memWe}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 rspData after reset", rspData, 32'd0);
    chk("R1 rspValid after reset", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic testOpen();
    wr(8'd5, 32'hA5A5_0001);
    chk("R2 memWe on open write", {31'd0, oWe}, 32'd1);
    chk("R9 rspValid after write", {31'd0, oRv}, 32'd1);
    chk("R9 write rspData zero", oData, 32'd0);
    chk("R2 no errors on write", {30'd0, oAe, oCe}, 32'd0);
    rd(8'd5);
    chk("R2 read back", oData, 32'hA5A5_0001);
    chk("R2 read no errors", {30'd0, oAe, oCe}, 32'd0);
    chk("R11 low row rspHigh", {31'd0, oHi}, 32'd0);
    @(posedge clk); #1;
    chk("R9 idle rspValid", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic testReadOnly();
    wr(8'd10, 32'h0000_1111);
    setAttr(8'd10, 2'b01);
    wr(8'd10, 32'h0000_2222);
    chk("R4 memWe blocked", {31'd0, oWe}, 32'd0);
    chk("R4 accErr", {30'd0, oAe, oCe}, 32'd1);
    rd(8'd10);
    chk("R3 read-only read data", oData, 32'h0000_1111);
    chk("R3 read-only read no error", {30'd0, oAe, oCe}, 32'd0);
  endtask

  task automatic testClosed();
    wr(8'd20, 32'h0000_3333);
    setAttr(8'd20, 2'b10);
    wr(8'd20, 32'h0000_4444);
    chk("R5 memWe blocked", {31'd0, oWe}, 32'd0);
    chk("R5 addrErr", {30'd0, oAe, oCe}, 32'd2);
    rd(8'd20);
    chk("R6 closed read zero", oData, 32'd0);
    chk("R6 closed read addrErr", {30'd0, oAe, oCe}, 32'd2);
    setAttr(8'd20, 2'b00);
    rd(8'd20);
    chk("R12 restored data", oData, 32'h0000_3333);
    chk("R12 restored no error", {30'd0, oAe, oCe}, 32'd0);
  endtask

  task automatic testCode3();
    wr(8'd30, 32'h0000_5555);
    setAttr(8'd30, 2'b11);
    wr(8'd30, 32'h0000_6666);
    chk("R7 code 11 write blocked", {31'd0, oWe}, 32'd0);
    chk("R7 code 11 write addrErr", {30'd0, oAe, oCe}, 32'd2);
    rd(8'd30);
    chk("R7 code 11 read zero", oData, 32'd0);
    chk("R7 code 11 read addrErr", {30'd0, oAe, oCe}, 32'd2);
    setAttr(8'd30, 2'b00);
    rd(8'd30);
    chk("R7 code 11 contents kept", oData, 32'h0000_5555);
  endtask

  task automatic testOutOfRange();
    wr(8'd72, 32'h0000_7272);
    wr(8'd200, 32'hDEAD_BEEF);
    chk("R8 no memWe for 200", {31'd0, oWe}, 32'd0);
    chk("R8 addrErr for 200", {30'd0, oAe, oCe}, 32'd2);
    chk("R11 out-of-range rspHigh", {31'd0, oHi}, 32'd0);
    rd(8'd72);
    chk("R8 aliased row intact", oData, 32'h0000_7272);
    rd(8'd128);
    chk("R8 read 128 zero", oData, 32'd0);
    chk("R8 read 128 addrErr", {30'd0, oAe, oCe}, 32'd2);
  endtask

  task automatic testSameCycle();
    access(1'b1, 8'd40, 32'h0000_4040, 1'b1, 8'd40, 2'b01);
    chk("R10 same-cycle write uses old code", {31'd0, oWe}, 32'd1);
    chk("R10 same-cycle no error", {30'd0, oAe, oCe}, 32'd0);
    wr(8'd40, 32'h0000_9999);
    chk("R10 next write refused", {30'd0, oAe, oCe}, 32'd1);
    rd(8'd40);
    chk("R10 data from same-cycle write", oData, 32'h0000_4040);
    setAttr(8'd130, 2'b10);
    wr(8'd2, 32'h0000_0202);
    chk("R10 out-of-range config ignored", {31'd0, oWe}, 32'd1);
    chk("R10 row 2 no error", {30'd0, oAe, oCe}, 32'd0);
  endtask

  task automatic testHigh();
    wr(8'd100, 32'h0000_1000);
    chk("R11 high row rspHigh", {31'd0, oHi}, 32'd1);
    rd(8'd64);
    chk("R11 boundary row 64 high", {31'd0, oHi}, 32'd1);
    rd(8'd63);
    chk("R11 row 63 low", {31'd0, oHi}, 32'd0);
    rd(8'd100);
    chk("R11 high row data", oData, 32'h0000_1000);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testOpen();
    testReadOnly();
    testClosed();
    testCode3();
    testOutOfRange();
    testSameCycle();
    testHigh();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule